// File: doc/BRIEF.md
# USB Function Control and Interrupt Registers

This block is the small register file that a local microcontroller uses to steer a USB device function. It sits on a byte-wide bus with a write strobe and a combinational read path. It holds two registers. The interrupt enable register gates a byte of event status flags into one interrupt request line. The control register drives the pull-up enable, the function-enable signal and the remote wake-up request. It also decides whether a USB bus reset is passed on to the rest of the chip as a device reset.

The block handles a USB bus reset selectively. The function-enable bit always clears. The connect bit and the reset-propagation bit never change. When propagation is enabled, the interrupt enables and the wake-up request clear as well, and the reset output follows the bus reset one cycle later. When propagation is disabled, everything except function enable keeps its value and the reset output stays low. The USB serial engine, suspend and resume detection, and resume signalling are outside the block.

Top module: `usbf_ctl_top`

## Requirements
- R1: After rst_n is released, both registers read 0, and irq, pullup_oe, func_en, wake_req and rst_out are all 0.
- R2: A write strobe to offset 0xFD loads the interrupt enable register on the next rising clock edge. The bit map is: bit 7 function reset, bit 6 suspend, bit 5 resume, bit 4 start-of-frame, bit 3 pseudo start-of-frame, bit 2 setup stage, bit 0 setup overwrite. Bit 1 is reserved: it ignores writes and always reads 0.
- R3: A write strobe to offset 0xFC loads the control register on the next rising clock edge. The bit map is: bit 7 connect, which drives pullup_oe (1 = drive the pull-up, 0 = high impedance); bit 6 function enable, which drives func_en; bit 5 wake-up request, which drives wake_req; bit 4 reset propagation. Bits 3:0 ignore writes and read 0.
- R4: A cycle with usb_rst high clears function enable on the next edge, whatever the value of reset propagation.
- R5: usb_rst never changes the connect bit or the reset-propagation bit. Only a control write changes them.
- R6: When reset propagation is 1, a cycle with usb_rst high clears the interrupt enable register and the wake-up request on the next edge.
- R7: rst_out is high in the cycle after each cycle in which usb_rst is high while reset propagation is 1, and is low otherwise.
- R8: When reset propagation is 0, usb_rst leaves the interrupt enable register and the wake-up request unchanged, and rst_out stays low.
- R9: irq is combinationally 1 exactly when some enable bit and the matching status bit are both 1. Status bit 1 never raises irq.
- R10: When usb_rst and a write strobe occur in the same cycle, the clearing done by the bus reset takes priority over the written value. Bits that the bus reset does not clear take the written value.
- R11: Reads at any offset other than 0xFC and 0xFD return 0. Write strobes at those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| wr_stb | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 8 | Read data for addr, combinational |
| usb_rst | input | 1 | USB bus reset detected, level per cycle |
| evt_status | input | 8 | Event status flags, same bit map as the enable register |
| irq | output | 1 | Interrupt request |
| pullup_oe | output | 1 | Pull-up pad drive enable |
| func_en | output | 1 | Function responds to bus transactions |
| wake_req | output | 1 | Remote wake-up request |
| rst_out | output | 1 | Propagated device reset |

## Verification
The interrupt path is exercised with single enable bits against a walking status bit, with reserved-bit-only status under full enable, and with disjoint enable and status sets. This separates a correct AND-OR from an OR of the status alone and from a leak through the reserved position. Bus resets are applied with reset propagation both on and off, lasting one and several cycles, so that bits which clear can be told apart from bits which must hold. They are also applied together with writes to each register, which shows the priority between the bus reset and a write. Writes and reads at unmapped offsets confirm that the decoder ignores them.

// File: rtl/usbf_ctl_pkg.sv
package usbf_ctl_pkg;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CTRL_FLD_W = 4;
  localparam int unsigned CTRL_LSB   = BYTE_W - CTRL_FLD_W;

  typedef struct packed {
    logic connect;
    logic fen;
    logic wake;
    logic rste;
  } ctrl_t;

  function automatic ctrl_t f_ctrl_unpack(input logic [CTRL_FLD_W-1:0] nib);
    ctrl_t c;
    c.connect = nib[3];
    c.fen     = nib[2];
    c.wake    = nib[1];
    c.rste    = nib[0];
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] f_ctrl_pack(input ctrl_t c);
    return {c.connect, c.fen, c.wake, c.rste, {CTRL_LSB{1'b0}}};
  endfunction

  function automatic ctrl_t f_ctrl_bus_reset(input ctrl_t nxt, input logic prop);
    ctrl_t c;
    c      = nxt;
    c.fen  = 1'b0;
    if (prop) c.wake = 1'b0;
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] f_mask_keep(input logic [BYTE_W-1:0] w,
                                                     input logic [BYTE_W-1:0] rsvd);
    return w & ~rsvd;
  endfunction

endpackage

// File: rtl/usbf_addr_dec.sv
module usbf_addr_dec #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'hFD,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'hFC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_stb,
  output logic              mask_sel,
  output logic              ctrl_sel,
  output logic              mask_we,
  output logic              ctrl_we
);
  assign mask_sel = (addr == MASK_OFS);
  assign ctrl_sel = (addr == CTRL_OFS);
  assign mask_we  = wr_stb & mask_sel;
  assign ctrl_we  = wr_stb & ctrl_sel;
endmodule

// File: rtl/usbf_mask_reg.sv
module usbf_mask_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RSVD = 'h02
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] q,
  output logic         rsvd_wr_hit
);
  assign rsvd_wr_hit = we & (|(wdata & RSVD));

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSVD[i]) begin : g_rsvd
      assign q[i] = 1'b0;
    end else begin : g_live
      logic b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   b <= 1'b0;
        else if (clr) b <= 1'b0;
        else if (we)  b <= wdata[i];
      end
      assign q[i] = b;
    end
  end
endmodule

// File: rtl/usbf_ctrl_reg.sv
module usbf_ctrl_reg
  import usbf_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [CTRL_FLD_W-1:0] wnib,
  input  logic                  bus_rst,
  output ctrl_t                 cur,
  output logic                  dev_rst_evt,
  output logic                  rst_out
);
  ctrl_t nxt;

  assign dev_rst_evt = bus_rst & cur.rste;

  always_comb begin
    nxt = cur;
    if (we)      nxt = f_ctrl_unpack(wnib);
    if (bus_rst) nxt = f_ctrl_bus_reset(nxt, cur.rste);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '0;
      rst_out <= 1'b0;
    end else begin
      cur     <= nxt;
      rst_out <= dev_rst_evt;
    end
  end
endmodule

// File: rtl/usbf_irq_merge.sv
module usbf_irq_merge #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] mask,
  input  logic [W-1:0] status,
  output logic [W-1:0] hit,
  output logic         irq
);
  for (genvar i = 0; i < W; i++) begin : g_and
    assign hit[i] = mask[i] & status[i];
  end
  assign irq = |hit;
endmodule

// File: rtl/usbf_ctl_top.sv
module usbf_ctl_top
  import usbf_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'hFD,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'hFC,
  parameter logic [BYTE_W-1:0] MASK_RSVD = 'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_stb,
  output logic [BYTE_W-1:0] rdata,
  input  logic              usb_rst,
  input  logic [BYTE_W-1:0] evt_status,
  output logic              irq,
  output logic              pullup_oe,
  output logic              func_en,
  output logic              wake_req,
  output logic              rst_out
);
  logic              mask_sel, ctrl_sel, mask_we, ctrl_we;
  logic [BYTE_W-1:0] mask_q;
  logic [BYTE_W-1:0] irq_hit;
  logic              rsvd_wr_hit;
  logic              dev_rst_evt;
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] ctrl_byte;

  usbf_addr_dec #(.ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS), .CTRL_OFS(CTRL_OFS)) u_dec (
    .addr(addr), .wr_stb(wr_stb), .mask_sel(mask_sel), .ctrl_sel(ctrl_sel),
    .mask_we(mask_we), .ctrl_we(ctrl_we)
  );

  usbf_mask_reg #(.W(BYTE_W), .RSVD(MASK_RSVD)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(wdata), .clr(dev_rst_evt),
    .q(mask_q), .rsvd_wr_hit(rsvd_wr_hit)
  );

  usbf_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wnib(wdata[BYTE_W-1:CTRL_LSB]),
    .bus_rst(usb_rst), .cur(ctrl_q), .dev_rst_evt(dev_rst_evt), .rst_out(rst_out)
  );

  usbf_irq_merge #(.W(BYTE_W)) u_irq (
    .mask(mask_q), .status(evt_status), .hit(irq_hit), .irq(irq)
  );

  assign ctrl_byte = f_ctrl_pack(ctrl_q);
  assign pullup_oe = ctrl_q.connect;
  assign func_en   = ctrl_q.fen;
  assign wake_req  = ctrl_q.wake;

  always_comb begin
    rdata = '0;
    if (mask_sel)      rdata = mask_q;
    else if (ctrl_sel) rdata = ctrl_byte;
  end
endmodule

// File: rtl/usbf_ctl_chk.sv
module usbf_ctl_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'hFD,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'hFC,
  parameter logic [7:0] MASK_RSVD = 'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              usb_rst,
  input logic [7:0]        evt_status,
  input logic              irq,
  input logic              pullup_oe,
  input logic              func_en,
  input logic              wake_req,
  input logic              rst_out,
  input logic              mask_we,
  input logic              ctrl_we,
  input logic [7:0]        mask_q,
  input logic [7:0]        ctrl_byte,
  input logic              dev_rst_evt,
  input logic              rsvd_wr_hit
);
  AST_MASK_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !dev_rst_evt) |=> (mask_q == ($past(wdata) & ~MASK_RSVD))); // R2
  AST_RSVD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_wr_hit |=> !mask_q[1]); // R2
  AST_CTRL_LOW_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTRL_OFS) |-> (rdata[3:0] == 4'h0)); // R3
  AST_FEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    usb_rst |=> !func_en); // R4
  AST_CONNECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_rst && !ctrl_we) |=> ($stable(pullup_oe) && $stable(ctrl_byte[4]))); // R5
  AST_PROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_evt |=> ((mask_q == 8'h00) && !wake_req)); // R6
  AST_RSTO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_evt |=> rst_out); // R7
  AST_RSTO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_evt |=> !rst_out); // R7
  AST_NOPROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_rst && !ctrl_byte[4] && !mask_we) |=> $stable(mask_q)); // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_status != 8'h00)); // R9
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> !irq); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr != MASK_OFS) && (addr != CTRL_OFS)) |-> (rdata == 8'h00)); // R11
endmodule

bind usbf_ctl_top usbf_ctl_chk #(
  .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS), .CTRL_OFS(CTRL_OFS), .MASK_RSVD(MASK_RSVD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
  .usb_rst(usb_rst), .evt_status(evt_status), .irq(irq), .pullup_oe(pullup_oe),
  .func_en(func_en), .wake_req(wake_req), .rst_out(rst_out), .mask_we(mask_we),
  .ctrl_we(ctrl_we), .mask_q(mask_q), .ctrl_byte(ctrl_byte),
  .dev_rst_evt(dev_rst_evt), .rsvd_wr_hit(rsvd_wr_hit)
);

// File: tb/tb_usbf_ctl_top.sv
`timescale 1ns/1ps
module tb_usbf_ctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       wr_stb = 1'b0;
  logic [7:0] rdata;
  logic       usb_rst = 1'b0;
  logic [7:0] evt_status = 8'h00;
  logic       irq, pullup_oe, func_en, wake_req, rst_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  int m_mask = 0;
  bit m_con = 0, m_fen = 0, m_wake = 0, m_rste = 0, m_rsto = 0;

  always #4 clk = ~clk;

  usbf_ctl_top dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_stb(wr_stb),
    .rdata(rdata), .usb_rst(usb_rst), .evt_status(evt_status), .irq(irq),
    .pullup_oe(pullup_oe), .func_en(func_en), .wake_req(wake_req), .rst_out(rst_out)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    if (addr == 8'hFD) return m_mask;
    if (addr == 8'hFC) return (int'(m_con) << 7) | (int'(m_fen) << 6) |
                              (int'(m_wake) << 5) | (int'(m_rste) << 4);
    return 0;
  endfunction

  function automatic bit exp_irq();
    for (int i = 0; i < 8; i++)
      if (m_mask[i] && evt_status[i]) return 1;
    return 0;
  endfunction

  task automatic compare(string tag);
    chk(tag, "rdata", int'(rdata), exp_rdata());
    chk(tag, "irq", int'(irq), int'(exp_irq()));
    chk(tag, "pullup_oe", int'(pullup_oe), int'(m_con));
    chk(tag, "func_en", int'(func_en), int'(m_fen));
    chk(tag, "wake_req", int'(wake_req), int'(m_wake));
    chk(tag, "rst_out", int'(rst_out), int'(m_rsto));
  endtask

  task automatic model_edge();
    int nm;
    bit ncon, nfen, nwake, nrste;
    if (!rst_n) begin
      m_mask = 0; m_con = 0; m_fen = 0; m_wake = 0; m_rste = 0; m_rsto = 0;
      return;
    end
    nm = m_mask; ncon = m_con; nfen = m_fen; nwake = m_wake; nrste = m_rste;
    if (wr_stb && addr == 8'hFD) nm = int'(wdata) & 8'hFD;
    if (wr_stb && addr == 8'hFC) begin
      ncon = wdata[7]; nfen = wdata[6]; nwake = wdata[5]; nrste = wdata[4];
    end
    if (usb_rst) begin
      nfen = 0;
      if (m_rste) begin nm = 0; nwake = 0; end
    end
    m_rsto = usb_rst && m_rste;
    m_mask = nm; m_con = ncon; m_fen = nfen; m_wake = nwake; m_rste = nrste;
  endtask

  // called at a falling edge with inputs already set
  task automatic cyc(string tag);
    #2;
    compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_stb = 1'b1;
    cyc(tag);
    wr_stb = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a);
    addr = a;
    cyc(tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst_n = 1'b1;
    rd("R1", 8'hFD); rd("R1", 8'hFC);

    // enable register bit map and reserved bit
    wr("R2", 8'hFD, 8'hFF); rd("R2", 8'hFD);
    wr("R2", 8'hFD, 8'hA5); rd("R2", 8'hFD);
    wr("R2", 8'hFD, 8'h02); rd("R2", 8'hFD);
    wr("R2", 8'hFD, 8'h5A); rd("R2", 8'hFD);

    // control register
    wr("R3", 8'hFC, 8'hFF); rd("R3", 8'hFC);
    wr("R3", 8'hFC, 8'h5A); rd("R3", 8'hFC);
    wr("R3", 8'hFC, 8'h0F); rd("R3", 8'hFC);

    // interrupt combination
    wr("R9", 8'hFD, 8'h81);
    evt_status = 8'h80; rd("R9", 8'hFD);
    evt_status = 8'h01; rd("R9", 8'hFD);
    evt_status = 8'h7E; rd("R9", 8'hFD);
    wr("R9", 8'hFD, 8'hFF);
    evt_status = 8'h02; rd("R9", 8'hFD);
    for (int i = 0; i < 8; i++) begin
      evt_status = 8'h01 << i; rd("R9", 8'hFD);
    end
    wr("R9", 8'hFD, 8'h10);
    for (int i = 0; i < 8; i++) begin
      evt_status = 8'h01 << i; rd("R9", 8'hFD);
    end
    evt_status = 8'h00;

    // bus reset with propagation off
    wr("R8", 8'hFD, 8'h3C);
    wr("R8", 8'hFC, 8'hE0);
    addr = 8'hFD;
    usb_rst = 1'b1; cyc("R4"); cyc("R8");
    usb_rst = 1'b0; cyc("R5"); rd("R8", 8'hFD); rd("R5", 8'hFC);
    evt_status = 8'h04; rd("R8", 8'hFD); evt_status = 8'h00;

    // bus reset with propagation on
    wr("R6", 8'hFD, 8'hFF);
    wr("R6", 8'hFC, 8'hF0);
    addr = 8'hFC;
    usb_rst = 1'b1; cyc("R7"); cyc("R7"); cyc("R6");
    usb_rst = 1'b0; cyc("R7"); rd("R6", 8'hFD); rd("R5", 8'hFC); cyc("R7");
    // single-cycle pulse
    wr("R6", 8'hFD, 8'h0C);
    usb_rst = 1'b1; rd("R7", 8'hFD);
    usb_rst = 1'b0; rd("R7", 8'hFD); rd("R6", 8'hFD);

    // bus reset and write in the same cycle
    usb_rst = 1'b1; wr("R10", 8'hFD, 8'hFF); usb_rst = 1'b0;
    rd("R10", 8'hFD);
    usb_rst = 1'b1; wr("R10", 8'hFC, 8'h70); usb_rst = 1'b0;
    rd("R10", 8'hFC);
    usb_rst = 1'b1; wr("R10", 8'hFC, 8'hE0); usb_rst = 1'b0;
    rd("R10", 8'hFC);
    usb_rst = 1'b1; wr("R10", 8'hFD, 8'h24); usb_rst = 1'b0;
    rd("R10", 8'hFD);

    // unmapped offsets
    wr("R11", 8'hFD, 8'h99);
    wr("R11", 8'h00, 8'hFF);
    wr("R11", 8'hFE, 8'h00);
    wr("R11", 8'hFB, 8'h66);
    rd("R11", 8'h10); rd("R11", 8'hFE); rd("R11", 8'hFD); rd("R11", 8'hFC);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule